// File: doc/BRIEF.md
# Flash Array Sleep Controller

This block keeps track of a low-power sleep state for each of several flash arrays. The default is two arrays. Software puts an array to sleep with a one-cycle enable strobe and brings it back with a one-cycle disable strobe. A status bit tells software whether the array is out of normal service.

Any access request that reaches a sleeping array starts the wake on its own. The requester is held off through the recovery time, with ready low, until the array can be used again. The recovery time is the parameter `WAKE_CYCLES`, counted in clock cycles; the default of 240 gives about 5 µs at 48 MHz.

Each array has its own three-state machine with the states awake, asleep and waking. Every input and output is one bit per array, and bit g always belongs to array g.

Top module: `flash_sleep_ctrl`

## Requirements
- R1: After reset every array is awake: `sleep_o` is 0, `asleep_o` is 0 and `acc_rdy_o` is 1.
- R2: An enable strobe on an awake array, with no disable strobe in the same cycle, makes both `sleep_o` and `asleep_o` read 1 from the next cycle on.
- R3: A disable strobe on a sleeping array starts the wake. `sleep_o` drops in the next cycle. `asleep_o` stays 1 for exactly `WAKE_CYCLES` cycles and then reads 0.
- R4: An access request seen while an array sleeps starts the same wake. A request held from that cycle sees `acc_rdy_o` rise exactly `WAKE_CYCLES`+1 cycles later.
- R5: The disable strobe wins over the enable strobe when both arrive in the same cycle. An awake array stays awake, and a sleeping array starts to wake.
- R6: An enable strobe during a wake neither shortens nor lengthens the wake. When the wake ends, the array spends one cycle awake with ready high and then sleeps again. A disable strobe later in the same wake cancels that pending enable.
- R7: An enable strobe on a sleeping array has no effect, and a disable strobe on an awake array has no effect.
- R8: The arrays are independent: strobes and requests for one array never change the outputs of another.
- R9: `acc_rdy_o` is 1 exactly when the array is awake, so it is 0 throughout sleep and the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_set_i | input | NUM_INST | Enable strobe, one bit per array |
| sleep_clr_i | input | NUM_INST | Disable strobe, one bit per array |
| acc_req_i | input | NUM_INST | Access request, one bit per array |
| sleep_o | output | NUM_INST | Array held in low-power mode |
| asleep_o | output | NUM_INST | Status: asleep or still waking |
| acc_rdy_o | output | NUM_INST | Array can serve an access |

## Verification
The enable and disable strobes can reach one array in the same cycle, both while it is awake and while it sleeps. The bench drives both strobes together in each of those states and expects the disable to win. An enable can also arrive while a wake is still counting. The bench places it a few cycles into a wake and counts the cycles exactly: the full wake, then one awake cycle, then sleep. A later disable must cancel that pending enable.

// File: rtl/flash_sleep_ctrl.sv
module flash_sleep_ctrl #(
  parameter int NUM_INST    = 2,
  parameter int WAKE_CYCLES = 240
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_INST-1:0] sleep_set_i,
  input  logic [NUM_INST-1:0] sleep_clr_i,
  input  logic [NUM_INST-1:0] acc_req_i,
  output logic [NUM_INST-1:0] sleep_o,
  output logic [NUM_INST-1:0] asleep_o,
  output logic [NUM_INST-1:0] acc_rdy_o
);

  localparam int CW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(WAKE_CYCLES - 1);

  typedef enum logic [1:0] {ST_AWAKE, ST_ASLEEP, ST_WAKING} pwr_state_t;

  for (genvar g = 0; g < NUM_INST; g++) begin : g_inst
    pwr_state_t    st;
    logic [CW-1:0] cnt;
    logic          pend;
    logic          go_sleep;

    // a pending enable acts like a fresh strobe once the array is awake
    assign go_sleep = (sleep_set_i[g] | pend) & ~sleep_clr_i[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st   <= ST_AWAKE;
        cnt  <= '0;
        pend <= 1'b0;
      end else begin
        unique case (st)
          ST_AWAKE: begin
            pend <= 1'b0;
            if (go_sleep) st <= ST_ASLEEP;
          end
          ST_ASLEEP: begin
            if (sleep_clr_i[g] | acc_req_i[g]) begin
              st  <= ST_WAKING;
              cnt <= CNT_LOAD;
            end
          end
          ST_WAKING: begin
            if (sleep_clr_i[g])      pend <= 1'b0;
            else if (sleep_set_i[g]) pend <= 1'b1;
            if (cnt == '0) st  <= ST_AWAKE;
            else           cnt <= cnt - 1'b1;
          end
          default: st <= ST_AWAKE;
        endcase
      end
    end

    assign sleep_o[g]   = (st == ST_ASLEEP);
    assign asleep_o[g]  = (st != ST_AWAKE);
    assign acc_rdy_o[g] = (st == ST_AWAKE);
  end

endmodule

// File: rtl/flash_sleep_ctrl_chk.sv
module flash_sleep_ctrl_chk #(
  parameter int NUM_INST = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_INST-1:0] sleep_set_i,
  input logic [NUM_INST-1:0] sleep_clr_i,
  input logic [NUM_INST-1:0] acc_req_i,
  input logic [NUM_INST-1:0] sleep_o,
  input logic [NUM_INST-1:0] asleep_o,
  input logic [NUM_INST-1:0] acc_rdy_o
);
  for (genvar g = 0; g < NUM_INST; g++) begin : g_chk
    // R2
    enter_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep_o[g] && sleep_set_i[g] && !sleep_clr_i[g]) |=> sleep_o[g]);
    // R3
    sw_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_o[g] && sleep_clr_i[g]) |=> (!sleep_o[g] && asleep_o[g]));
    // R4
    acc_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_o[g] && acc_req_i[g]) |=> (!sleep_o[g] && asleep_o[g]));
    // R5
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep_o[g] && sleep_set_i[g] && sleep_clr_i[g]) |=> !asleep_o[g]);
    // R7
    set_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_o[g] && !sleep_clr_i[g] && !acc_req_i[g]) |=> sleep_o[g]);
    // R9
    rdy_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rdy_o[g] |-> !asleep_o[g]);
    // R9
    sleep_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_o[g] |-> (asleep_o[g] && !acc_rdy_o[g]));
  end
endmodule

bind flash_sleep_ctrl flash_sleep_ctrl_chk #(.NUM_INST(NUM_INST)) u_chk (.*);

// File: tb/tb_flash_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_flash_sleep_ctrl;
  localparam int N = 2;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] set_s = '0, clr_s = '0, acc = '0;
  logic [N-1:0] slp, st, rdy;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_sleep_ctrl #(.NUM_INST(N), .WAKE_CYCLES(W)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_set_i(set_s), .sleep_clr_i(clr_s),
    .acc_req_i(acc), .sleep_o(slp), .asleep_o(st), .acc_rdy_o(rdy));

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse(input logic [N-1:0] s, input logic [N-1:0] c);
    set_s = s; clr_s = c; tick(); set_s = '0; clr_s = '0;
  endtask

  task automatic settle();
    repeat (W + 3) tick();
  endtask

  task automatic t_reset();
    chk(slp == 2'b00, "R1 sleep", slp, 0);
    chk(st  == 2'b00, "R1 status", st, 0);
    chk(rdy == 2'b11, "R1 ready", rdy, 3);
  endtask

  task automatic t_enter();
    pulse(2'b01, 2'b00);
    chk(slp[0] && st[0], "R2 enter", {slp[0], st[0]}, 3);
    chk(!rdy[0], "R9 ready low asleep", rdy[0], 0);
    chk(st[1] == 0 && rdy[1], "R8 other array", st[1], 0);
  endtask

  task automatic t_ignored();
    pulse(2'b01, 2'b00);
    tick();
    chk(slp[0] && st[0], "R7 set while asleep", slp[0], 1);
    pulse(2'b00, 2'b10);
    chk(st[1] == 0 && rdy[1], "R7 clr while awake", st[1], 0);
  endtask

  task automatic t_sw_wake();
    pulse(2'b00, 2'b01);
    chk(!slp[0] && st[0], "R3 waking", {slp[0], st[0]}, 1);
    repeat (W - 1) tick();
    chk(st[0] && !rdy[0], "R3 still waking at last cycle", st[0], 1);
    tick();
    chk(!st[0] && rdy[0], "R3 awake after wake", st[0], 0);
  endtask

  task automatic t_acc_wake();
    int n = 0;
    pulse(2'b01, 2'b00);
    acc[0] = 1'b1;
    while (!rdy[0] && n < 4 * W) begin
      tick(); n++;
      if (n == 1) chk(!slp[0] && st[0], "R4 wake started", slp[0], 0);
    end
    acc[0] = 1'b0;
    chk(n == W + 1, "R4 stall length", n, W + 1);
    chk(!st[0], "R4 status after wake", st[0], 0);
  endtask

  task automatic t_both();
    pulse(2'b01, 2'b01);
    chk(!st[0] && !slp[0], "R5 both while awake", st[0], 0);
    pulse(2'b01, 2'b00);
    pulse(2'b01, 2'b01);
    chk(!slp[0] && st[0], "R5 both while asleep wakes", slp[0], 0);
    settle();
    chk(!st[0], "R5 awake after wake", st[0], 0);
  endtask

  task automatic t_pending();
    pulse(2'b01, 2'b00);
    pulse(2'b00, 2'b01);
    repeat (3) tick();
    pulse(2'b01, 2'b00);
    repeat (7) tick();
    chk(st[0] && !slp[0], "R6 wake not cut short", st[0], 1);
    tick();
    chk(!st[0] && rdy[0], "R6 one awake cycle", st[0], 0);
    tick();
    chk(slp[0] && st[0], "R6 pending enable honoured", slp[0], 1);
    pulse(2'b00, 2'b01);
    pulse(2'b01, 2'b00);
    pulse(2'b00, 2'b01);
    settle();
    chk(!st[0] && !slp[0], "R6 pending cancelled", st[0], 0);
  endtask

  task automatic t_indep();
    pulse(2'b11, 2'b00);
    chk(slp == 2'b11, "R8 both asleep", slp, 3);
    acc[1] = 1'b1;
    tick();
    chk(slp[0] && !slp[1], "R8 access wakes only its array", slp, 1);
    repeat (W) tick();
    acc[1] = 1'b0;
    chk(rdy[1] && slp[0] && !rdy[0], "R8 independent ready", rdy, 2);
    pulse(2'b00, 2'b01);
    settle();
    chk(st == 2'b00, "R8 all awake", st, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_enter();
    t_ignored();
    t_sw_wake();
    t_acc_wake();
    t_both();
    t_pending();
    t_indep();
    finish_run();
  end
endmodule